// File: doc/BRIEF.md
# Memory Bus Wiring Test Engine

This block is a hardware self-test sequencer. It takes over a simple synchronous memory master port and looks for wiring faults between a memory controller and its devices. A single access is in flight at a time. A read returns its data a fixed number of cycles after the read strobe. The engine runs in two phases and then reports a verdict. In the data phase it walks a single set bit across the data lines at one address chosen by the caller. In the address phase it checks that the power-of-two offsets inside a region never alias one another.

The address phase uses a fill value, `FILL_PAT`, and its bitwise inverse. It stores the fill value at every power-of-two offset. It then writes the inverse at one location at a time and confirms that no other offset changed. Address lines that are stuck high, stuck low or shorted together make two offsets decode to the same cell, so the change shows up somewhere else. The caller pulses `start` and waits for `done`. It then reads `pass`, the phase code, and either the first failing data pattern or the first failing address.

State machine: `ST_IDLE`/`ST_DONE` go to `ST_DB_WR` on start. The data phase loops `ST_DB_WR` → `ST_DB_RD` → `ST_DB_CMP`. A mismatch goes to `ST_DONE`. The last pattern goes to `ST_AF_WR`, and any other pattern shifts and returns to `ST_DB_WR`. `ST_AF_WR` fills the offsets, then moves to `ST_SH_INV` → `ST_SH_RD` ⇄ `ST_SH_CMP` → `ST_SH_RST` for the stuck-high check. After that the stuck-low and short check loops over `ST_SL_INV` → `ST_SL_RD` ⇄ `ST_SL_CMP` → `ST_SL_RST` → `ST_SL_INV` until the test offsets run out, and then enters `ST_DONE`.

Top module: `mem_wire_test`

## Requirements
- R1: A one-cycle `start` in idle or done starts a run. `done` falls in the cycle after `start` and rises only when the run ends. It stays high, with the memory port idle, until the next `start`.
- R2: The data phase writes the patterns 1, 2, 4, … up to the top data bit to `data_addr`, one pattern per data line, from bit 0 upward.
- R3: Each data-phase write is followed in the next cycle by a read of the same address. The read value is compared `RD_LAT` cycles after the read strobe, before the next pattern is written.
- R4: On a data-phase mismatch the engine stops with `done`=1, `pass`=0, `phase`=1 and `fail_pattern` equal to the pattern that failed. `fail_addr` is 0 and no address-phase access is made.
- R5: The tested offsets are `WORD_BYTES`<<k for k = 0, 1, …, as long as the offset ANDed with (`region_size`−1) is nonzero. Each access goes to `region_base` + offset.
- R6: The address phase first writes `FILL_PAT` to every tested offset, in ascending order.
- R7: The stuck-high check writes ~`FILL_PAT` to `region_base` and reads each offset in ascending order, expecting `FILL_PAT`. It then writes `FILL_PAT` back to `region_base`. A mismatch stops the run with `fail_addr` equal to the address that was read.
- R8: The stuck-low and short check visits each tested offset T in ascending order. It writes ~`FILL_PAT` at T, reads every other offset in ascending order (T itself is skipped) expecting `FILL_PAT`, and restores `FILL_PAT` at T. A mismatch stops the run with `fail_addr` = `region_base`+T.
- R9: A run without mismatches ends with `pass`=1, `phase`=3, and `fail_pattern` and `fail_addr` both 0. An address-phase failure ends with `phase`=2 and `fail_pattern`=0.
- R10: `mem_we` and `mem_re` are never high together, and no new read is issued while one is outstanding.
- R11: After reset `done`, `pass`, `phase`, `mem_we` and `mem_re` are all 0.
- R12: If no offset passes the mask (`region_size` ≤ `WORD_BYTES`), the address phase only writes ~`FILL_PAT` and then `FILL_PAT` to `region_base`, and the run passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a run |
| data_addr | input | ADDR_W | Address used by the data phase |
| region_base | input | ADDR_W | Base address of the region tested in the address phase |
| region_size | input | ADDR_W+1 | Region size in address units (power of two, ≥1) |
| mem_addr | output | ADDR_W | Memory access address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | DATA_W | Read data, valid RD_LAT cycles after `mem_re` |
| done | output | 1 | Run finished; held until the next start |
| pass | output | 1 | Verdict, valid while done |
| phase | output | 2 | 0 idle, 1 data phase, 2 address phase, 3 passed |
| fail_pattern | output | DATA_W | First failing data pattern, else 0 |
| fail_addr | output | ADDR_W | First failing address, else 0 |

## Verification
Some properties hold on every cycle, and the assertions check them: a write and a read never overlap, data-phase writes carry one-hot data and are each followed at once by a read, address-phase writes carry only the fill value or its inverse, and a finished engine leaves the bus idle and reports a clean verdict. The order of offsets, the skipping of the test offset, and the address reported for each kind of wiring fault can only be shown by the bench scenarios. The bench compares every access against a behavioural model running on a memory that has injected data-line faults and stuck or shorted address lines.

// File: rtl/mwt_pkg.sv
package mwt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DB_WR,
        ST_DB_RD,
        ST_DB_CMP,
        ST_AF_WR,
        ST_SH_INV,
        ST_SH_RD,
        ST_SH_CMP,
        ST_SH_RST,
        ST_SL_INV,
        ST_SL_RD,
        ST_SL_CMP,
        ST_SL_RST,
        ST_DONE
    } mwt_state_e;

    localparam logic [1:0] PH_IDLE = 2'd0;
    localparam logic [1:0] PH_DATA = 2'd1;
    localparam logic [1:0] PH_ADDR = 2'd2;
    localparam logic [1:0] PH_PASS = 2'd3;

endpackage

// File: rtl/mwt_pow2_cursor.sv
module mwt_pow2_cursor #(
    parameter int OFF_W      = 17,
    parameter int WORD_BYTES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [OFF_W-1:0] mask,
    output logic [OFF_W-1:0] off,
    output logic             valid
);

    localparam logic [OFF_W-1:0] FIRST_OFF = OFF_W'(WORD_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off <= '0;
        end else if (load) begin
            off <= FIRST_OFF;
        end else if (step) begin
            off <= off << 1;
        end
    end

    assign valid = |(off & mask);

    // R5: the sequencer never restarts and advances a cursor in one cycle
    assert_no_load_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step));

endmodule

// File: rtl/mwt_lat_timer.sv
module mwt_lat_timer #(
    parameter int RD_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic ready
);

    localparam int CNT_W = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(RD_LAT - 1);

    logic [CNT_W-1:0] cnt;
    logic             busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (arm) begin
            cnt  <= LOAD_V;
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign ready = busy && (cnt == '0);

    // R10: a read is never issued while another is outstanding
    assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> !busy);

endmodule

// File: rtl/mem_wire_test.sv
module mem_wire_test
    import mwt_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int RD_LAT     = 2,
    parameter int WORD_BYTES = 1,
    parameter logic [DATA_W-1:0] FILL_PAT = DATA_W'('hAA)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [ADDR_W-1:0] region_base,
    input  logic [ADDR_W:0]   region_size,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              pass,
    output logic [1:0]        phase,
    output logic [DATA_W-1:0] fail_pattern,
    output logic [ADDR_W-1:0] fail_addr
);

    localparam int OFF_W = ADDR_W + 1;
    localparam logic [DATA_W-1:0] INV_PAT = ~FILL_PAT;

    mwt_state_e state, nxt;

    logic [ADDR_W-1:0] daddr_q, base_q;
    logic [OFF_W-1:0]  mask_q;
    logic [DATA_W-1:0] db_pat;

    logic              ld_cfg, pat_shl, to_addr, fail_p, fail_a, ok_end;
    logic [ADDR_W-1:0] fail_a_val;
    logic              r_load, r_step, t_load, t_step, arm, lat_ready;
    logic [OFF_W-1:0]  r_off, t_off;
    logic              r_valid, t_valid;
    logic [ADDR_W-1:0] r_addr, t_addr;

    mwt_pow2_cursor #(.OFF_W(OFF_W), .WORD_BYTES(WORD_BYTES)) u_rd_cursor (
        .clk(clk), .rst_n(rst_n), .load(r_load), .step(r_step),
        .mask(mask_q), .off(r_off), .valid(r_valid)
    );

    mwt_pow2_cursor #(.OFF_W(OFF_W), .WORD_BYTES(WORD_BYTES)) u_tst_cursor (
        .clk(clk), .rst_n(rst_n), .load(t_load), .step(t_step),
        .mask(mask_q), .off(t_off), .valid(t_valid)
    );

    mwt_lat_timer #(.RD_LAT(RD_LAT)) u_lat (
        .clk(clk), .rst_n(rst_n), .arm(arm), .ready(lat_ready)
    );

    assign r_addr = base_q + r_off[ADDR_W-1:0];
    assign t_addr = base_q + t_off[ADDR_W-1:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state and sequencing controls
    always_comb begin
        nxt        = state;
        ld_cfg     = 1'b0;
        pat_shl    = 1'b0;
        to_addr    = 1'b0;
        fail_p     = 1'b0;
        fail_a     = 1'b0;
        fail_a_val = '0;
        ok_end     = 1'b0;
        r_load     = 1'b0;
        r_step     = 1'b0;
        t_load     = 1'b0;
        t_step     = 1'b0;
        arm        = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    ld_cfg = 1'b1;
                    nxt    = ST_DB_WR;
                end
            end
            ST_DB_WR: nxt = ST_DB_RD;
            ST_DB_RD: begin
                arm = 1'b1;
                nxt = ST_DB_CMP;
            end
            ST_DB_CMP: begin
                if (lat_ready) begin
                    if (mem_rdata != db_pat) begin
                        fail_p = 1'b1;
                        nxt    = ST_DONE;
                    end else if (db_pat[DATA_W-1]) begin
                        to_addr = 1'b1;
                        r_load  = 1'b1;
                        nxt     = ST_AF_WR;
                    end else begin
                        pat_shl = 1'b1;
                        nxt     = ST_DB_WR;
                    end
                end
            end
            ST_AF_WR: begin
                if (r_valid) begin
                    r_step = 1'b1;
                end else begin
                    r_load = 1'b1;
                    nxt    = ST_SH_INV;
                end
            end
            ST_SH_INV: nxt = ST_SH_RD;
            ST_SH_RD: begin
                if (r_valid) begin
                    arm = 1'b1;
                    nxt = ST_SH_CMP;
                end else begin
                    nxt = ST_SH_RST;
                end
            end
            ST_SH_CMP: begin
                if (lat_ready) begin
                    if (mem_rdata != FILL_PAT) begin
                        fail_a     = 1'b1;
                        fail_a_val = r_addr;
                        nxt        = ST_DONE;
                    end else begin
                        r_step = 1'b1;
                        nxt    = ST_SH_RD;
                    end
                end
            end
            ST_SH_RST: begin
                t_load = 1'b1;
                nxt    = ST_SL_INV;
            end
            ST_SL_INV: begin
                if (t_valid) begin
                    r_load = 1'b1;
                    nxt    = ST_SL_RD;
                end else begin
                    ok_end = 1'b1;
                    nxt    = ST_DONE;
                end
            end
            ST_SL_RD: begin
                if (!r_valid) begin
                    nxt = ST_SL_RST;
                end else if (r_off == t_off) begin
                    r_step = 1'b1;
                end else begin
                    arm = 1'b1;
                    nxt = ST_SL_CMP;
                end
            end
            ST_SL_CMP: begin
                if (lat_ready) begin
                    if (mem_rdata != FILL_PAT) begin
                        fail_a     = 1'b1;
                        fail_a_val = t_addr;
                        nxt        = ST_DONE;
                    end else begin
                        r_step = 1'b1;
                        nxt    = ST_SL_RD;
                    end
                end
            end
            ST_SL_RST: begin
                t_step = 1'b1;
                nxt    = ST_SL_INV;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Memory port outputs
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        unique case (state)
            ST_DB_WR: begin
                mem_we    = 1'b1;
                mem_addr  = daddr_q;
                mem_wdata = db_pat;
            end
            ST_DB_RD: begin
                mem_re   = 1'b1;
                mem_addr = daddr_q;
            end
            ST_AF_WR: begin
                mem_we    = r_valid;
                mem_addr  = r_addr;
                mem_wdata = FILL_PAT;
            end
            ST_SH_INV: begin
                mem_we    = 1'b1;
                mem_addr  = base_q;
                mem_wdata = INV_PAT;
            end
            ST_SH_RD: begin
                mem_re   = r_valid;
                mem_addr = r_addr;
            end
            ST_SH_RST: begin
                mem_we    = 1'b1;
                mem_addr  = base_q;
                mem_wdata = FILL_PAT;
            end
            ST_SL_INV: begin
                mem_we    = t_valid;
                mem_addr  = t_addr;
                mem_wdata = INV_PAT;
            end
            ST_SL_RD: begin
                mem_re   = r_valid && (r_off != t_off);
                mem_addr = r_addr;
            end
            ST_SL_RST: begin
                mem_we    = 1'b1;
                mem_addr  = t_addr;
                mem_wdata = FILL_PAT;
            end
            default: begin
                mem_we = 1'b0;
            end
        endcase
    end

    // Configuration, data pattern and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            daddr_q      <= '0;
            base_q       <= '0;
            mask_q       <= '0;
            db_pat       <= '0;
            done         <= 1'b0;
            pass         <= 1'b0;
            phase        <= PH_IDLE;
            fail_pattern <= '0;
            fail_addr    <= '0;
        end else begin
            if (ld_cfg) begin
                daddr_q      <= data_addr;
                base_q       <= region_base;
                mask_q       <= region_size - 1'b1;
                db_pat       <= DATA_W'(1);
                done         <= 1'b0;
                pass         <= 1'b0;
                phase        <= PH_DATA;
                fail_pattern <= '0;
                fail_addr    <= '0;
            end
            if (pat_shl) begin
                db_pat <= db_pat << 1;
            end
            if (to_addr) begin
                phase <= PH_ADDR;
            end
            if (fail_p) begin
                fail_pattern <= db_pat;
                done         <= 1'b1;
            end
            if (fail_a) begin
                fail_addr <= fail_a_val;
                done      <= 1'b1;
            end
            if (ok_end) begin
                done  <= 1'b1;
                pass  <= 1'b1;
                phase <= PH_PASS;
            end
        end
    end

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_done_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_done_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_we && !mem_re));

    assert_onehot_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && mem_we) |-> $onehot(mem_wdata));

    assert_readback_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && mem_we) |=> (mem_re && $stable(mem_addr)));

    assert_addr_values_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ADDR && mem_we) |-> (mem_wdata == FILL_PAT || mem_wdata == INV_PAT));

    assert_pass_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> (phase == PH_PASS && fail_pattern == '0 && fail_addr == '0));

    assert_fail_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass) |-> (phase == PH_DATA || phase == PH_ADDR));

endmodule

// File: tb/mem_wire_test_tb.sv
module mem_wire_test_tb_top;

    localparam int AW  = 12;
    localparam int DW  = 8;
    localparam int LAT = 2;
    localparam int WB  = 1;
    localparam int PAT = 'hAA;
    localparam int INV = 'h55;
    localparam int AMASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] data_addr = '0;
    logic [AW-1:0] region_base = '0;
    logic [AW:0]   region_size = '0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we, mem_re;
    logic [DW-1:0] mem_rdata;
    logic          done, pass;
    logic [1:0]    phase;
    logic [DW-1:0] fail_pattern;
    logic [AW-1:0] fail_addr;

    always #5 clk = ~clk;

    mem_wire_test #(
        .ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT), .WORD_BYTES(WB), .FILL_PAT(8'hAA)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .data_addr(data_addr),
        .region_base(region_base), .region_size(region_size),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .done(done), .pass(pass), .phase(phase),
        .fail_pattern(fail_pattern), .fail_addr(fail_addr)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // Fault injection: address stuck high / stuck low / two shorted lines, data stuck bits
    int ash = 0, asl = 0, ashort = 0, dsh = 0, dsl = 0;
    logic [DW-1:0] mem [int];

    function automatic int phys(int a);
        int p;
        p = (a | ash) & ~asl;
        if ((p & ashort) != 0) p = p | ashort;
        return p & AMASK;
    endfunction

    function automatic int m_rd(int a);
        int p;
        int v;
        p = phys(a);
        v = mem.exists(p) ? int'(mem[p]) : 0;
        return ((v | dsh) & ~dsl) & 'hFF;
    endfunction

    function automatic void m_wr(int a, int d);
        mem[phys(a)] = d[DW-1:0];
    endfunction

    // Memory model with fixed read latency
    logic [DW-1:0] pipe [LAT];
    assign mem_rdata = pipe[LAT-1];
    always @(posedge clk) begin
        if (mem_we) m_wr(int'(mem_addr), int'(mem_wdata));
        pipe[0] <= mem_re ? DW'(m_rd(int'(mem_addr))) : '0;
        for (int k = 1; k < LAT; k++) pipe[k] <= pipe[k-1];
    end

    // Reference access stream and results
    bit ref_w [$];
    int ref_a [$];
    int ref_d [$];
    int e_pass, e_phase, e_fpat, e_faddr;

    function automatic void push(bit w, int a, int d);
        ref_w.push_back(w);
        ref_a.push_back(a & AMASK);
        ref_d.push_back(d);
    endfunction

    task automatic run_model(int daddr, int base, int size);
        int offs [$];
        e_pass = 0; e_phase = 1; e_fpat = 0; e_faddr = 0;
        for (int i = 0; i < DW; i++) begin
            int p;
            p = 1 << i;
            push(1, daddr, p); m_wr(daddr, p);
            push(0, daddr, 0);
            if (m_rd(daddr) != p) begin e_fpat = p; return; end
        end
        e_phase = 2;
        for (int o = WB; ((o & (size - 1)) != 0) && (o <= AMASK); o = o << 1) offs.push_back(o);
        foreach (offs[i]) begin push(1, base + offs[i], PAT); m_wr((base + offs[i]) & AMASK, PAT); end
        push(1, base, INV); m_wr(base, INV);
        foreach (offs[i]) begin
            push(0, base + offs[i], 0);
            if (m_rd((base + offs[i]) & AMASK) != PAT) begin e_faddr = (base + offs[i]) & AMASK; return; end
        end
        push(1, base, PAT); m_wr(base, PAT);
        foreach (offs[t]) begin
            push(1, base + offs[t], INV); m_wr((base + offs[t]) & AMASK, INV);
            foreach (offs[o]) begin
                if (o != t) begin
                    push(0, base + offs[o], 0);
                    if (m_rd((base + offs[o]) & AMASK) != PAT) begin e_faddr = (base + offs[t]) & AMASK; return; end
                end
            end
            push(1, base + offs[t], PAT); m_wr((base + offs[t]) & AMASK, PAT);
        end
        e_phase = 3; e_pass = 1;
    endtask

    // Cycle-by-cycle comparison of the access stream
    bit run_active = 1'b0;
    int seq_err = 0;
    always @(negedge clk) begin
        bit w;
        int a, d;
        if (run_active) begin
            if (done && !start && ref_w.size() != 0) seq_err++;
            if (mem_we && mem_re) seq_err++;
            if (mem_we || mem_re) begin
                if (ref_w.size() == 0) begin
                    seq_err++;
                end else begin
                    w = ref_w.pop_front();
                    a = ref_a.pop_front();
                    d = ref_d.pop_front();
                    if (mem_we !== w || int'(mem_addr) != a || (w && int'(mem_wdata) != d)) seq_err++;
                end
            end
        end
    end

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic run_case(string tag, int daddr, int base, int size);
        int wait_cyc;
        mem.delete();
        ref_w.delete(); ref_a.delete(); ref_d.delete();
        run_model(daddr, base, size);
        mem.delete();
        seq_err = 0;
        @(posedge clk); #1;
        data_addr = AW'(daddr); region_base = AW'(base); region_size = (AW+1)'(size);
        start = 1'b1; run_active = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        chk({tag, " R1 done low while running"}, int'(done), 0);
        wait_cyc = 0;
        while (!done && wait_cyc < 20000) begin
            @(negedge clk);
            wait_cyc++;
        end
        run_active = 1'b0;
        chk({tag, " R1 run finished"}, int'(done), 1);
        chk({tag, " R9 pass"}, int'(pass), e_pass);
        chk({tag, " R9 phase"}, int'(phase), e_phase);
        chk({tag, " R4 fail_pattern"}, int'(fail_pattern), e_fpat);
        chk({tag, " R7 R8 fail_addr"}, int'(fail_addr), e_faddr);
        chk({tag, " R2 R3 R5 R6 R10 access stream errors"}, seq_err + ref_w.size(), 0);
        repeat (3) @(negedge clk);
        chk({tag, " R1 done held"}, int'(done), 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < LAT; k++) pipe[k] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 done", int'(done), 0);
        chk("R11 pass", int'(pass), 0);
        chk("R11 phase", int'(phase), 0);
        chk("R11 bus idle", int'(mem_we | mem_re), 0);

        run_case("good R9", 'h123, 'h400, 'h100);
        chk("R9 good pass", int'(pass), 1);

        dsl = 'h08;
        run_case("data stuck low R4", 'h123, 'h400, 'h100);
        chk("R4 stuck-low line reported", int'(fail_pattern), 'h08);
        dsl = 0;

        dsh = 'h01;
        run_case("data stuck high R4", 'h0F0, 'h400, 'h100);
        chk("R4 stuck-high line reported", int'(fail_pattern), 'h02);
        dsh = 0;

        ash = 'h004;
        run_case("addr stuck high R7", 'h123, 'h400, 'h100);
        chk("R7 stuck-high address", int'(fail_addr), 'h404);
        ash = 0;

        asl = 'h020;
        run_case("addr stuck low R8", 'h123, 'h400, 'h100);
        chk("R8 stuck-low fails", int'(pass), 0);
        asl = 0;

        ashort = 'h00A;
        run_case("addr short R8", 'h123, 'h400, 'h100);
        chk("R8 short fails in address phase", int'(phase), 2);
        ashort = 0;

        dsl = 'h80; ash = 'h010;
        run_case("data fault skips address R4", 'h055, 'h400, 'h100);
        dsl = 0; ash = 0;

        run_case("no offsets R12", 'h010, 'h200, 1);
        chk("R12 passes", int'(pass), 1);

        run_case("full range R5", 'h7FF, 'h000, 'h1000);

        ash = 'h100;
        run_case("stuck high outside region R5", 'h123, 'h400, 'h100);
        ash = 0;

        run_case("restart after fail R1", 'h001, 'h800, 'h40);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule